// File: doc/BRIEF.md
# DDR2 Command Spacing Checker

This block sits beside a DDR2 controller and watches every command it sends to one rank of devices. For each command it checks the minimum spacing rules between row activation, column access, precharge and refresh, and raises a registered violation flag together with a code that has one bit per broken rule. All limits are taken at run time from two packed timing words. Each limit is a cycle count, normally worked out as floor(ns / 5 ns) + 1 for a 5 ns clock. Each of the eight banks keeps its own row timers. Rank-wide timers cover activate-to-activate spacing, the four-activate window and the refresh recovery time.

The block also keeps a free-running refresh interval counter. It pulses a one-cycle refresh-due strobe each time the interval expires, so the controller knows when to issue a refresh. The checker never blocks or changes commands. It only reports. Every command updates the timers, including one that breaks a rule.

Top module: `ddr_timing_checker`

## Requirements
- R1: Command encoding is 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PREA, 6 REF, 7 MRS. A RD or WR to a bank k cycles after an ACT to the same bank, with k below the row word field [15:12] (activate-to-column), sets code bit 0.
- R2: A PRE to a bank k cycles after an ACT to that bank, with k below row word field [5:0] (minimum row open time), sets code bit 1. A PREA sets bit 1 when any bank is still inside that time.
- R3: An ACT to a bank k cycles after the previous ACT to the same bank, with k below row word field [11:6] (row cycle time), sets code bit 2.
- R4: An ACT to any bank k cycles after the previous ACT to any bank, with k below row word field [23:20], sets code bit 3.
- R5: An ACT issued while four earlier ACTs all lie fewer than W cycles back sets code bit 4. W is power word field [29:24].
- R6: Any command other than NOP issued k cycles after a REF, with k below row word field [31:24], sets code bit 5.
- R7: The flag and code are registered. They appear in the cycle after the offending command and last exactly one cycle. When several rules break at once, several code bits are set, and the flag is the OR of the code.
- R8: NOP never raises the flag. A command that breaks no rule leaves the flag low. Timers of different banks are independent. A limit of 0 or 1 imposes no restriction.
- R9: The refresh-due output pulses high for one cycle every REF_INTERVAL cycles (default 1560, 7.8 us at 200 MHz). The first pulse comes REF_INTERVAL+2 rising edges after rst_n rises.
- R10: rst_n resets asynchronously and is released through a two-stage synchronizer. While in reset, and just after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one cycle per command slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 3 | Command issued this cycle |
| cmd_bank | input | 3 | Bank address of the command |
| row_timing | input | 32 | Packed row timing limits in cycles |
| power_timing | input | 32 | Packed power timing word; only the activate window field is used |
| viol_flag | output | 1 | High for one cycle after an offending command |
| viol_code | output | 6 | One bit per broken rule |
| refresh_due | output | 1 | One-cycle strobe when a refresh is due |

## Verification
On every cycle the assertions check several things. A NOP is never flagged. Back-to-back ACT and column, ACT and ACT, or REF and command pairs raise their rule bit whenever the limit is at least two. The flag always agrees with the code. The refresh strobe is a single cycle and its spacing matches the interval. Exact boundary behaviour needs the bench's directed scenarios: a flag one cycle below each limit and silence at the limit. The same goes for per-bank independence, the rolling four-activate window, PREA looking across all banks, and several bits set by one command.

// File: rtl/ddr_tchk_pkg.sv
package ddr_tchk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } dram_cmd_e;

  localparam int NUM_RULES = 6;
  localparam int RULE_RCD  = 0;
  localparam int RULE_RAS  = 1;
  localparam int RULE_RC   = 2;
  localparam int RULE_RRD  = 3;
  localparam int RULE_FAW  = 4;
  localparam int RULE_RFC  = 5;

  typedef struct packed {
    logic [7:0] rfc;
    logic [3:0] rrd;
    logic [3:0] rp;
    logic [3:0] rcd;
    logic [5:0] rc;
    logic [5:0] ras;
  } row_word_t;

endpackage

// File: rtl/ddr_tchk_downcnt.sv
// Saturating down counter: load L, busy for the next L-1 cycles.
module ddr_tchk_downcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] limit,
  output logic         busy
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) begin
      cnt_d = (limit == '0) ? '0 : limit - 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/ddr_bank_timers.sv
// Per-bank row timers: activate-to-column, row open time, row cycle.
module ddr_bank_timers #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_valid,
  input  logic [BANK_W-1:0]    act_bank,
  input  logic [3:0]           lim_rcd,
  input  logic [5:0]           lim_ras,
  input  logic [5:0]           lim_rc,
  output logic [NUM_BANKS-1:0] rcd_busy,
  output logic [NUM_BANKS-1:0] ras_busy,
  output logic [NUM_BANKS-1:0] rc_busy
);

  logic [NUM_BANKS-1:0] bank_hit;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_hit[b] = act_valid && (act_bank == BANK_W'(b));
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    ddr_tchk_downcnt #(.W(4)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(bank_hit[g]), .limit(lim_rcd), .busy(rcd_busy[g])
    );
    ddr_tchk_downcnt #(.W(6)) u_ras (
      .clk(clk), .rst_n(rst_n), .load(bank_hit[g]), .limit(lim_ras), .busy(ras_busy[g])
    );
    ddr_tchk_downcnt #(.W(6)) u_rc (
      .clk(clk), .rst_n(rst_n), .load(bank_hit[g]), .limit(lim_rc), .busy(rc_busy[g])
    );
  end

endmodule

// File: rtl/ddr_faw_window.sv
// Rolling window of the most recent DEPTH activates; full when all are live.
module ddr_faw_window #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_valid,
  input  logic [W-1:0] limit,
  output logic         full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [DEPTH-1:0] slot_busy;
  logic [DEPTH-1:0] slot_load;

  always_comb begin
    ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    for (int s = 0; s < DEPTH; s++) begin
      slot_load[s] = act_valid && (ptr_q == PTR_W'(s));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (act_valid) begin
      ptr_q <= ptr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    ddr_tchk_downcnt #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(slot_load[g]), .limit(limit), .busy(slot_busy[g])
    );
  end

  assign full = &slot_busy;

endmodule

// File: rtl/ddr_refresh_tick.sv
// Free-running interval counter with a registered one-cycle strobe.
module ddr_refresh_tick #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic due
);

  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;
  logic             due_q;

  always_comb begin
    wrap  = (cnt_q == CNT_LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      due_q <= wrap;
    end
  end

  assign due = due_q;

endmodule

// File: rtl/ddr_timing_checker.sv
module ddr_timing_checker
  import ddr_tchk_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int FAW_DEPTH    = 4,
  localparam int BANK_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_code,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [31:0]          row_timing,
  input  logic [31:0]          power_timing,
  output logic                 viol_flag,
  output logic [NUM_RULES-1:0] viol_code,
  output logic                 refresh_due
);

  // Reset: asynchronous assert, synchronous release.
  logic rst_s1;
  logic rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  row_word_t row;
  logic [5:0] lim_faw;
  logic       unused_fields;

  assign row           = row_word_t'(row_timing);
  assign lim_faw       = power_timing[29:24];
  assign unused_fields = ^{row.rp, power_timing[31:30], power_timing[23:0]};

  // Command decode
  logic is_nop, is_act, is_col, is_pre, is_prea, is_ref;

  always_comb begin
    is_nop  = (cmd_code == CMD_NOP);
    is_act  = (cmd_code == CMD_ACT);
    is_col  = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);
    is_pre  = (cmd_code == CMD_PRE);
    is_prea = (cmd_code == CMD_PREA);
    is_ref  = (cmd_code == CMD_REF);
  end

  // Timers
  logic [NUM_BANKS-1:0] rcd_busy, ras_busy, rc_busy;
  logic rrd_busy, rfc_busy, faw_full;

  ddr_bank_timers #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst_n(rst_i),
    .act_valid(is_act), .act_bank(cmd_bank),
    .lim_rcd(row.rcd), .lim_ras(row.ras), .lim_rc(row.rc),
    .rcd_busy(rcd_busy), .ras_busy(ras_busy), .rc_busy(rc_busy)
  );

  ddr_tchk_downcnt #(.W(4)) u_rrd (
    .clk(clk), .rst_n(rst_i), .load(is_act), .limit(row.rrd), .busy(rrd_busy)
  );

  ddr_tchk_downcnt #(.W(8)) u_rfc (
    .clk(clk), .rst_n(rst_i), .load(is_ref), .limit(row.rfc), .busy(rfc_busy)
  );

  ddr_faw_window #(.DEPTH(FAW_DEPTH), .W(6)) u_faw (
    .clk(clk), .rst_n(rst_i), .act_valid(is_act), .limit(lim_faw), .full(faw_full)
  );

  ddr_refresh_tick #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_i), .due(refresh_due)
  );

  // Rule evaluation
  logic [NUM_RULES-1:0] code_d;

  always_comb begin
    code_d           = '0;
    code_d[RULE_RCD] = is_col && rcd_busy[cmd_bank];
    code_d[RULE_RAS] = (is_pre && ras_busy[cmd_bank]) || (is_prea && (|ras_busy));
    code_d[RULE_RC]  = is_act && rc_busy[cmd_bank];
    code_d[RULE_RRD] = is_act && rrd_busy;
    code_d[RULE_FAW] = is_act && faw_full;
    code_d[RULE_RFC] = !is_nop && rfc_busy;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      viol_code <= '0;
      viol_flag <= 1'b0;
    end else begin
      viol_code <= code_d;
      viol_flag <= |code_d;
    end
  end

endmodule

// File: rtl/ddr_tchk_props.sv
module ddr_tchk_props
  import ddr_tchk_pkg::*;
#(
  parameter int REF_INTERVAL = 1560
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_code,
  input logic [2:0]           cmd_bank,
  input logic [31:0]          row_timing,
  input logic                 viol_flag,
  input logic [NUM_RULES-1:0] viol_code,
  input logic                 refresh_due
);

  localparam int GAP_W = $clog2(REF_INTERVAL + 4) + 1;

  logic             past_ok;
  logic             seen_ref;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok  <= 1'b0;
      seen_ref <= 1'b0;
      gap      <= '0;
    end else begin
      past_ok <= 1'b1;
      if (refresh_due) begin
        seen_ref <= 1'b1;
        gap      <= '0;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R8: NOP is never flagged
  a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_NOP) |=> !viol_flag);

  // R1: column command right after ACT to same bank
  a_r1_rcd_back2back: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cmd_code) == CMD_ACT && (cmd_code == CMD_RD || cmd_code == CMD_WR)
     && cmd_bank == $past(cmd_bank) && $stable(row_timing) && row_timing[15:12] >= 4'd2)
    |=> viol_code[RULE_RCD]);

  // R4: two ACTs on consecutive cycles
  a_r4_rrd_back2back: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cmd_code) == CMD_ACT && cmd_code == CMD_ACT
     && $stable(row_timing) && row_timing[23:20] >= 4'd2)
    |=> viol_code[RULE_RRD]);

  // R6: non-NOP command right after REF
  a_r6_rfc_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cmd_code) == CMD_REF && cmd_code != CMD_NOP
     && $stable(row_timing) && row_timing[31:24] >= 8'd2)
    |=> viol_code[RULE_RFC]);

  // R7: flag agrees with code
  a_r7_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag == (viol_code != '0));

  // R9: strobe lasts one cycle
  a_r9_ref_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_due |=> !refresh_due);

  // R9: strobes are REF_INTERVAL cycles apart
  a_r9_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_due && seen_ref) |-> (gap == GAP_W'(REF_INTERVAL - 1)));

endmodule

bind ddr_timing_checker ddr_tchk_props #(.REF_INTERVAL(REF_INTERVAL)) u_props (
  .clk(clk), .rst_n(rst_i), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
  .row_timing(row_timing), .viol_flag(viol_flag), .viol_code(viol_code),
  .refresh_due(refresh_due)
);

// File: tb/sim_ddr_timing_checker.sv
`timescale 1ns/1ps
module sim_ddr_timing_checker;
  import ddr_tchk_pkg::*;

  localparam int INTERVAL = 1560;
  // limits in cycles: floor(ns/5)+1
  localparam logic [31:0] ROW_DEF = {8'd26, 4'd2, 4'd4, 4'd4, 6'd13, 6'd10};
  localparam logic [31:0] ROW_FAW = {8'd26, 4'd1, 4'd4, 4'd4, 6'd13, 6'd10};
  localparam logic [31:0] PWR_DEF = {2'b00, 6'd8, 8'hC8, 8'h02, 4'h3, 4'h2};

  logic       clk;
  logic       rst_n;
  logic [2:0] cmd_code;
  logic [2:0] cmd_bank;
  logic [31:0] row_timing;
  logic [31:0] power_timing;
  logic       viol_flag;
  logic [5:0] viol_code;
  logic       refresh_due;

  int n_tests = 0;
  int n_fail  = 0;
  int edge_cnt = 0;
  int ref_first = -1;
  int ref_second = -1;
  int ref_count = 0;
  int ref_wide = 0;
  logic ref_prev = 1'b0;

  ddr_timing_checker u0 (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .row_timing(row_timing), .power_timing(power_timing),
    .viol_flag(viol_flag), .viol_code(viol_code), .refresh_due(refresh_due)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      edge_cnt = 0;
      ref_prev = 1'b0;
    end else begin
      edge_cnt++;
      if (refresh_due) begin
        if (ref_prev) ref_wide++;
        else begin
          ref_count++;
          if (ref_count == 1) ref_first = edge_cnt;
          if (ref_count == 2) ref_second = edge_cnt;
        end
      end
      ref_prev = refresh_due;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  // check {flag, code} after a command
  task automatic chk_v(input string req, input logic [5:0] exp);
    chk(req, int'({viol_flag, viol_code}), int'({|exp, exp}));
  endtask

  task automatic issue(input logic [2:0] c, input logic [2:0] b);
    cmd_code = c;
    cmd_bank = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(CMD_NOP, 3'd0);
  endtask

  task automatic t_reset();
    chk("R10 flag", int'(viol_flag), 0);
    chk("R10 code", int'(viol_code), 0);
    chk("R10 refresh", int'(refresh_due), 0);
  endtask

  task automatic t_rcd();
    issue(CMD_ACT, 3'd2); chk_v("R1 act", 6'h00);
    issue(CMD_RD, 3'd5);  chk_v("R8 other bank rd", 6'h00);
    idle(20);
    issue(CMD_ACT, 3'd2);
    issue(CMD_RD, 3'd2);  chk_v("R1 rd gap1", 6'h01);
    idle(20);
    issue(CMD_ACT, 3'd3); idle(2);
    issue(CMD_WR, 3'd3);  chk_v("R1 wr gap3", 6'h01);
    idle(20);
    issue(CMD_ACT, 3'd4); idle(3);
    issue(CMD_RD, 3'd4);  chk_v("R1 rd gap4", 6'h00);
    idle(20);
  endtask

  task automatic t_ras();
    issue(CMD_ACT, 3'd1); idle(8);
    issue(CMD_PRE, 3'd1); chk_v("R2 pre gap9", 6'h02);
    idle(20);
    issue(CMD_ACT, 3'd3); idle(9);
    issue(CMD_PRE, 3'd3); chk_v("R2 pre gap10", 6'h00);
    idle(20);
    issue(CMD_ACT, 3'd6); idle(2);
    issue(CMD_PREA, 3'd0); chk_v("R2 prea", 6'h02);
    idle(20);
  endtask

  task automatic t_rc();
    issue(CMD_ACT, 3'd4); idle(11);
    issue(CMD_ACT, 3'd4); chk_v("R3 act gap12", 6'h04);
    idle(12);
    issue(CMD_ACT, 3'd4); chk_v("R3 act gap13", 6'h00);
    idle(20);
  endtask

  task automatic t_rrd();
    issue(CMD_ACT, 3'd0);
    issue(CMD_ACT, 3'd1); chk_v("R4 gap1", 6'h08);
    issue(CMD_NOP, 3'd0); chk_v("R7 one cycle", 6'h00);
    issue(CMD_ACT, 3'd2); chk_v("R4 gap2", 6'h00);
    idle(20);
  endtask

  task automatic t_faw();
    row_timing = ROW_FAW;
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      issue(CMD_ACT, 3'(b)); chk_v("R5 first four", 6'h00);
    end
    issue(CMD_ACT, 3'd4); chk_v("R5 fifth", 6'h10);
    idle(7);
    issue(CMD_ACT, 3'd5); chk_v("R5 window clear", 6'h00);
    idle(20);
    row_timing = ROW_DEF;
    @(negedge clk);
  endtask

  task automatic t_rfc();
    int bad = 0;
    issue(CMD_REF, 3'd0); chk_v("R6 ref", 6'h00);
    for (int i = 0; i < 24; i++) begin
      issue(CMD_NOP, 3'd0);
      if (viol_flag) bad++;
    end
    chk("R8 nop in rfc", bad, 0);
    issue(CMD_MRS, 3'd0); chk_v("R6 mrs gap25", 6'h20);
    issue(CMD_RD, 3'd7);  chk_v("R6 rd gap26", 6'h00);
    idle(20);
  endtask

  task automatic t_multi();
    issue(CMD_ACT, 3'd6);
    issue(CMD_ACT, 3'd6); chk_v("R7 two rules", 6'h0C);
    issue(CMD_NOP, 3'd0); chk_v("R7 clears", 6'h00);
    idle(20);
  endtask

  task automatic t_refresh();
    while (edge_cnt < 2 * INTERVAL + 6) @(negedge clk);
    chk("R9 first strobe", ref_first, INTERVAL + 2);
    chk("R9 second strobe", ref_second, 2 * INTERVAL + 2);
    chk("R9 width", ref_wide, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_code = CMD_NOP;
    cmd_bank = 3'd0;
    row_timing = ROW_DEF;
    power_timing = PWR_DEF;
    repeat (3) @(negedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    idle(5);
    t_rcd();
    t_ras();
    t_rc();
    t_rrd();
    t_faw();
    t_rfc();
    t_multi();
    t_refresh();
    summary();
    $finish;
  end

endmodule